// File: doc/BRIEF.md
# Timer Compare Channel Pulse Generator

This block is a single output-compare channel that sits beside a free-running 31-bit time counter. Software loads a target count through a small register port. When the counter reaches that exact value, the channel latches an event flag. Depending on how it is configured, it also raises an interrupt, raises a DMA request, and acts on an output pin.

In the high-pulse mode the pin is high for exactly one clock per match. Software can build a once-per-second pulse by loading a new target every second. Because the compare register is double-buffered, software can run one event ahead: it writes the target two events out while the next one is still armed.

The counter wraps modulo 2^31, so a target may lie beyond the wrap point. A global overflow-enable input decides whether such a target may fire after the wrap.

The register port has no handshake. It accepts one write per cycle when `reg_wr` is high. Reads are combinational on `rd_sel`.

Top module: `tcmp_channel`

## Requirements
- R1: After reset, the control word and the compare word both read 0, and `pin_out`, `irq` and `dma_req` are low.
- R2: Control word layout:
  - bit 0 is the DMA enable;
  - bits 5:2 are the mode;
  - bit 6 is the interrupt enable;
  - bit 7 is the event flag;
  - all other bits read 0.
  A written mode, including 0, reads back in the cycle right after the write.
- R3: A match happens when the mode is nonzero, a target is active, and `cnt_val` exactly equals that target at a clock edge. The flag then reads 1 after that edge, and never before it. A compare write made while no target is active becomes the active target immediately.
- R4: A compare write made while a target is active is held as the pending target. The compare word keeps reading the active target until the active target fires; the pending target then becomes active. A target that fires with nothing pending leaves the channel disarmed, and it never fires again.
- R5: Mode 0xF (high pulse): `pin_out` is high in exactly the one cycle after a match edge, then low.
- R6: Mode 0x5 (toggle): `pin_out` inverts on every match and otherwise holds its level.
- R7: Any other nonzero mode (for example 0x4 or 0x9) sets the flag on a match and leaves `pin_out` unchanged.
- R8: Writing 1 to control bit 7 clears the flag. Writing 0 to bit 7 leaves the flag unchanged.
- R9: If a match and a clear of the flag fall in the same cycle, the flag stays set.
- R10: `irq` is high exactly while the flag and the interrupt enable are both set. `dma_req` is high exactly while the flag and the DMA enable are both set.
- R11: Writing mode 0 does three things:
  - it drops both the active and the pending target;
  - it drives `pin_out` low in the next cycle;
  - it stops all further pulses.
- R12: Compare writes keep only bits 30:0. The channel treats the counter as having wrapped when `cnt_val` decreases. A target reached only after such a wrap fires when `ovf_evt_en` is 1, and is suppressed when `ovf_evt_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control word, 1 compare word |
| reg_wdata | input | 32 | Write data |
| rd_sel | input | 1 | Read select: 0 control word, 1 active compare word |
| rd_data | output | 32 | Read data (combinational) |
| cnt_val | input | 31 | Current value of the shared time counter |
| ovf_evt_en | input | 1 | Allow matches on targets that lie past a counter wrap |
| pin_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The bench puts the double buffer under load. It checks that a second compare write does not replace the armed target early, that it does take over at the first fire, and that a channel with nothing pending stays silent when the counter returns to the old target. A design that loaded writes straight into the active slot, or re-fired a spent target, would pulse at the wrong count.

It clears the flag in the very cycle of a match, where clear-wins logic would lose the event. It writes 0 to the flag bit, which a design that cleared on any control write would get wrong. It disables the channel with a pending target still queued, which stale pending logic would let fire.

It places a target just past the counter wrap, once with the overflow enable set and once with it clear. A design that ignored the wrap, or that kept bit 31 of a written target, would fire in the wrong cases or never.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  // control word field positions (software decodes these)
  localparam int unsigned F_DRE     = 0;
  localparam int unsigned F_MODE_LO = 2;
  localparam int unsigned F_MODE_W  = 4;
  localparam int unsigned F_IE      = 6;
  localparam int unsigned F_FLAG    = 7;
  localparam int unsigned CTRL_W    = 8;

  typedef logic [F_MODE_W-1:0] mode_t;

  localparam mode_t MODE_OFF     = 4'h0;
  localparam mode_t MODE_TOGGLE  = 4'h5;
  localparam mode_t MODE_HIPULSE = 4'hF;

  // packed so that the bit order equals the control word layout
  typedef struct packed {
    logic  flag;
    logic  ie;
    mode_t mode;
    logic  rsvd;
    logic  dre;
  } ctrl_t;

  typedef enum logic [1:0] {
    PIN_HOLD   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_PULSE  = 2'd2
  } pin_act_e;

  function automatic pin_act_e pin_action(input mode_t m);
    case (m)
      MODE_TOGGLE:  pin_action = PIN_TOGGLE;
      MODE_HIPULSE: pin_action = PIN_PULSE;
      default:      pin_action = PIN_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/tcmp_ctrl.sv
module tcmp_ctrl
  import tcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              match,
  output ctrl_t             ctrl_q,
  output logic              mode_off_wr
);

  logic unused_rsvd;
  assign unused_rsvd = wdata[1];

  assign mode_off_wr = wr_ctrl && (wdata[F_MODE_LO +: F_MODE_W] == MODE_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.dre  <= wdata[F_DRE];
        ctrl_q.mode <= wdata[F_MODE_LO +: F_MODE_W];
        ctrl_q.ie   <= wdata[F_IE];
      end
      ctrl_q.rsvd <= 1'b0;
      // a fresh match outranks a software clear in the same cycle
      if (match) begin
        ctrl_q.flag <= 1'b1;
      end else if (wr_ctrl && wdata[F_FLAG]) begin
        ctrl_q.flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tcmp_target.sv
module tcmp_target #(
  parameter int unsigned CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmp,
  input  logic [CNT_W-1:0] wdata,
  input  logic             disarm,
  input  logic             enabled,
  input  logic             ovf_en,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             match,
  output logic [CNT_W-1:0] act_q,
  output logic             act_vld
);

  logic [CNT_W-1:0] pend_q;
  logic             pend_vld;
  logic [CNT_W-1:0] cnt_prev;
  logic             prev_vld;
  logic             wrapped_q;
  logic             wrap_now;
  logic             blocked;

  assign wrap_now = prev_vld && (cnt_val < cnt_prev);
  assign blocked  = !ovf_en && (wrapped_q || wrap_now);
  assign match    = enabled && act_vld && (cnt_val == act_q) && !blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_prev <= '0;
      prev_vld <= 1'b0;
    end else begin
      cnt_prev <= cnt_val;
      prev_vld <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q     <= '0;
      act_vld   <= 1'b0;
      pend_q    <= '0;
      pend_vld  <= 1'b0;
      wrapped_q <= 1'b0;
    end else if (disarm) begin
      act_vld   <= 1'b0;
      pend_vld  <= 1'b0;
      wrapped_q <= 1'b0;
    end else begin
      if (act_vld && wrap_now) begin
        wrapped_q <= 1'b1;
      end
      if (wr_cmp) begin
        if (!act_vld || (match && !pend_vld)) begin
          // no live target after this edge: the write becomes active
          act_q     <= wdata;
          act_vld   <= 1'b1;
          wrapped_q <= 1'b0;
        end else if (match) begin
          // active fires, pending moves up, new write queues behind it
          act_q     <= pend_q;
          pend_q    <= wdata;
          wrapped_q <= 1'b0;
        end else begin
          pend_q   <= wdata;
          pend_vld <= 1'b1;
        end
      end else if (match) begin
        if (pend_vld) begin
          act_q     <= pend_q;
          pend_vld  <= 1'b0;
          wrapped_q <= 1'b0;
        end else begin
          act_vld <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tcmp_pin.sv
module tcmp_pin
  import tcmp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_t mode,
  input  logic  match,
  input  logic  force_low,
  output logic  pin_q
);

  pin_act_e act;
  assign act = pin_action(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (force_low) begin
      pin_q <= 1'b0;
    end else begin
      case (act)
        PIN_PULSE:  pin_q <= match;
        PIN_TOGGLE: pin_q <= pin_q ^ match;
        default:    pin_q <= pin_q;
      endcase
    end
  end

endmodule

// File: rtl/tcmp_channel.sv
module tcmp_channel
  import tcmp_pkg::*;
#(
  parameter int unsigned CNT_W  = 31,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              ovf_evt_en,
  output logic              pin_out,
  output logic              irq,
  output logic              dma_req
);

  localparam int unsigned CTRL_PAD = WORD_W - CTRL_W;
  localparam int unsigned CMP_PAD  = WORD_W - CNT_W;

  ctrl_t             ctrl_q;
  logic              mode_off_wr;
  logic              match_evt;
  logic [CNT_W-1:0]  act_q;
  logic              act_vld;
  logic              wr_ctrl;
  logic              wr_cmp;
  logic [WORD_W-1:0] cmp_rd;
  logic [WORD_W-1:0] ctrl_rd;
  logic              evt_flag;
  mode_t             cur_mode;

  assign wr_ctrl  = reg_wr && !reg_sel;
  assign wr_cmp   = reg_wr && reg_sel;
  assign evt_flag = ctrl_q.flag;
  assign cur_mode = ctrl_q.mode;

  tcmp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .wdata       (reg_wdata[CTRL_W-1:0]),
    .match       (match_evt),
    .ctrl_q      (ctrl_q),
    .mode_off_wr (mode_off_wr)
  );

  tcmp_target #(.CNT_W(CNT_W)) u_target (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_cmp  (wr_cmp),
    .wdata   (reg_wdata[CNT_W-1:0]),
    .disarm  (mode_off_wr),
    .enabled (cur_mode != MODE_OFF),
    .ovf_en  (ovf_evt_en),
    .cnt_val (cnt_val),
    .match   (match_evt),
    .act_q   (act_q),
    .act_vld (act_vld)
  );

  tcmp_pin u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cur_mode),
    .match     (match_evt),
    .force_low (mode_off_wr),
    .pin_q     (pin_out)
  );

  generate
    if (CMP_PAD > 0) begin : g_cmp_pad
      logic unused_wr_hi;
      assign unused_wr_hi = ^reg_wdata[WORD_W-1:CNT_W];
      assign cmp_rd = {{CMP_PAD{1'b0}}, act_q};
    end else begin : g_cmp_full
      assign cmp_rd = act_q;
    end
  endgenerate

  logic unused_vld;
  assign unused_vld = act_vld;

  assign ctrl_rd = {{CTRL_PAD{1'b0}}, ctrl_q};
  assign rd_data = rd_sel ? cmp_rd : ctrl_rd;
  assign irq     = ctrl_q.ie  && evt_flag;
  assign dma_req = ctrl_q.dre && evt_flag;

endmodule

// File: rtl/tcmp_channel_chk.sv
module tcmp_channel_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              pin_out,
  input logic              irq,
  input logic              match,
  input logic              flag,
  input logic [3:0]        mode
);

  // R9: a match always leaves the flag set, even against a clear
  a_r9_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);

  // R8: write-1-to-clear without a competing match empties the flag
  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[7] && !match) |=> !flag);

  // R11: a mode-0 write drops the pin on the next cycle
  a_r11_disable_drops_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && reg_wdata[5:2] == 4'h0) |=> !pin_out);

  // R5: in high-pulse mode the pin is only high right after a match
  a_r5_pulse_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out && $past(mode) == 4'hF) |-> $past(match));

  // R10: an interrupt only rises after a match or a control write
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(match || (reg_wr && !reg_sel)));

endmodule

bind tcmp_channel tcmp_channel_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .pin_out   (pin_out),
  .irq       (irq),
  .match     (match_evt),
  .flag      (evt_flag),
  .mode      (cur_mode)
);

// File: tb/sim_tcmp_channel.sv
module sim_tcmp_channel;

  localparam int unsigned CNT_W  = 31;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic [3:0] mode;
    logic       ie;
    logic       dre;
    logic [7:0] off;
    logic       pin1;
    logic       pin2;
    logic       irq;
    logic       dma;
  } vec_t;

  // mode, ie, dre, offset, pin after match, pin one cycle later, irq, dma
  localparam vec_t VECS [4] = '{
    '{4'hF, 1'b1, 1'b0, 8'd12, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'h5, 1'b0, 1'b1, 8'd7,  1'b1, 1'b1, 1'b0, 1'b1},
    '{4'h4, 1'b1, 1'b1, 8'd20, 1'b0, 1'b0, 1'b1, 1'b1},
    '{4'h9, 1'b0, 1'b0, 8'd3,  1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic              clk;
  logic              rst_n;
  logic              reg_wr;
  logic              reg_sel;
  logic [WORD_W-1:0] reg_wdata;
  logic              rd_sel;
  logic [WORD_W-1:0] rd_data;
  logic [CNT_W-1:0]  cnt;
  logic              ovf_evt_en;
  logic              pin_out;
  logic              irq;
  logic              dma_req;

  int checks = 0;
  int errors = 0;

  tcmp_channel #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .cnt_val    (cnt),
    .ovf_evt_en (ovf_evt_en),
    .pin_out    (pin_out),
    .irq        (irq),
    .dma_req    (dma_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one counter clock: outputs of that edge are settled on return
  task automatic step();
    @(posedge clk);
    #2;
    cnt = cnt + 31'd1;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_wr    = 1'b1;
    reg_sel   = sel;
    reg_wdata = d;
    step();
    reg_wr    = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
    rd_sel = 1'b0;
  endtask

  task automatic run_to(input logic [CNT_W-1:0] t);
    int n = 0;
    while (cnt != t && n < 100000) begin
      step();
      n++;
    end
  endtask

  // run n cycles and count pin-high cycles
  task automatic watch(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pin_out) highs++;
    end
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0]      v;
    logic [CNT_W-1:0] t;
    logic [CNT_W-1:0] t2;
    int               highs;

    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    rd_sel = 1'b0; cnt = 31'd100; ovf_evt_en = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl after reset", v, 32'h0);
    rd(1'b1, v); chk("R1 compare after reset", v, 32'h0);
    chk("R1 pin/irq/dma after reset", {29'h0, pin_out, irq, dma_req}, 32'h0);

    // R2 layout and immediate read-back
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, v); chk("R2 ctrl layout", v, 32'h0000_007D);
    wr(1'b0, 32'h0);
    rd(1'b0, v); chk("R2 mode zero read-back", v, 32'h0);

    // table of modes: R3 R5 R6 R7 R10 R11
    for (int i = 0; i < 4; i++) begin
      wr(1'b0, 32'h80);
      chk("R11 pin low after disable", {31'h0, pin_out}, 32'h0);
      t = cnt + 31'(VECS[i].off);
      wr(1'b1, {1'b0, t});
      wr(1'b0, {24'h0, 1'b0, VECS[i].ie, VECS[i].mode, 1'b0, VECS[i].dre});
      run_to(t);
      rd(1'b0, v); chk("R3 no flag before target", {31'h0, v[7]}, 32'h0);
      step();
      rd(1'b0, v); chk("R3 flag on exact match", {31'h0, v[7]}, 32'h1);
      chk("R5/R6/R7 pin after match", {31'h0, pin_out}, {31'h0, VECS[i].pin1});
      chk("R10 irq after match", {31'h0, irq}, {31'h0, VECS[i].irq});
      chk("R10 dma after match", {31'h0, dma_req}, {31'h0, VECS[i].dma});
      step();
      chk("R5/R6/R7 pin one cycle later", {31'h0, pin_out}, {31'h0, VECS[i].pin2});
    end

    // R4 double buffer
    wr(1'b0, 32'h80);
    t  = cnt + 31'd15;
    t2 = t + 31'd10;
    wr(1'b1, {1'b0, t});
    wr(1'b0, 32'h7C);
    wr(1'b1, {1'b0, t2});
    rd(1'b1, v); chk("R4 pending held, active unchanged", v, {1'b0, t});
    run_to(t);
    step();
    chk("R4 first target pulses", {31'h0, pin_out}, 32'h1);
    rd(1'b1, v); chk("R4 pending promoted", v, {1'b0, t2});
    wr(1'b0, 32'hFC);
    rd(1'b0, v); chk("R8 write 1 clears flag", {31'h0, v[7]}, 32'h0);
    run_to(t2);
    step();
    chk("R4 second target pulses", {31'h0, pin_out}, 32'h1);
    cnt = t2 - 31'd4;
    watch(8, highs);
    chk("R4 spent target never refires", 32'(highs), 32'h0);

    // R8 writing 0 to the flag bit leaves it
    wr(1'b0, 32'h7C);
    rd(1'b0, v); chk("R8 write 0 keeps flag", {31'h0, v[7]}, 32'h1);
    chk("R10 irq with flag and enable", {31'h0, irq}, 32'h1);
    wr(1'b0, 32'hFC);
    chk("R10 irq drops with flag", {31'h0, irq}, 32'h0);

    // R9 match and clear in the same cycle
    wr(1'b0, 32'h80);
    t = cnt + 31'd10;
    wr(1'b1, {1'b0, t});
    wr(1'b0, 32'h7C);
    run_to(t);
    wr(1'b0, 32'hFC);
    rd(1'b0, v); chk("R9 match beats clear", {31'h0, v[7]}, 32'h1);
    chk("R9 irq stays up", {31'h0, irq}, 32'h1);

    // R11 disable with a pending target queued
    wr(1'b0, 32'h80);
    t  = cnt + 31'd12;
    t2 = t + 31'd5;
    wr(1'b1, {1'b0, t});
    wr(1'b0, 32'h3C);
    wr(1'b1, {1'b0, t2});
    wr(1'b0, 32'h0);
    watch(24, highs);
    chk("R11 no pulses after disable", 32'(highs), 32'h0);
    rd(1'b0, v); chk("R11 no flag after disable", {31'h0, v[7]}, 32'h0);
    t = cnt + 31'd8;
    wr(1'b1, {1'b0, t});
    wr(1'b0, 32'h3C);
    run_to(t);
    step();
    chk("R3 first write after disable is active", {31'h0, pin_out}, 32'h1);

    // R12 target past the wrap, overflow enabled
    wr(1'b0, 32'h80);
    cnt = 31'h7FFF_FFF6;
    step();
    wr(1'b1, 32'h8000_0003);
    rd(1'b1, v); chk("R12 compare masked to 31 bits", v, 32'h3);
    wr(1'b0, 32'h3C);
    run_to(31'd3);
    step();
    chk("R12 fires after wrap when enabled", {31'h0, pin_out}, 32'h1);

    // R12 target past the wrap, overflow disabled
    ovf_evt_en = 1'b0;
    wr(1'b0, 32'h80);
    cnt = 31'h7FFF_FFF6;
    step();
    wr(1'b1, 32'h0000_0003);
    wr(1'b0, 32'h3C);
    watch(20, highs);
    chk("R12 suppressed across wrap when disabled", 32'(highs), 32'h0);
    rd(1'b0, v); chk("R12 no flag across wrap", {31'h0, v[7]}, 32'h0);
    wr(1'b0, 32'h80);
    t = cnt + 31'd6;
    wr(1'b1, {1'b0, t});
    wr(1'b0, 32'h3C);
    run_to(t);
    step();
    chk("R12 non-wrapping target fires when disabled", {31'h0, pin_out}, 32'h1);
    ovf_evt_en = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule